// File: doc/BRIEF.md
# Dual-Width Banked Byte FIFO

This block is the data buffer of a serial flash/peripheral interface. It holds four byte-wide FIFO lanes of 16 entries each. A host can move a whole 32-bit word in one access, which touches every lane at once. It can also move a single byte, which only ever touches lane 0. On the other side, the serial shifter pushes or pops one byte per strobe. The same instance serves as a transmit buffer (host pushes, serial pops) or as a receive buffer (serial pushes, host pops).

Because both widths share one store, a word stream sees 64 bytes of room while a byte stream sees 16. A mode input tells the serial side which layout is in use:
- In wide mode the serial pointers visit lanes 0, 1, 2, 3 in turn, so lane i carries byte i of each word.
- In narrow mode the serial side stays on lane 0.

The block raises latched status flags that are cleared by writing one, and it reports the fill level seen by each width. It also flags any access that it has to drop.

Top module: `bankfifo_top`

## Requirements
- R1: There are four lanes, each `DEPTH` (16) bytes deep. A word push stores `hostWordData[8i+7:8i]` into lane i. A word pop removes one entry from every lane. `hostRdData[8i+7:8i]` always shows the head of lane i. A word stream therefore holds 16 words (64 bytes).
- R2: The byte port reaches only lane 0. It pushes `hostByteData`, and its pop data is `hostRdData[7:0]`. A byte stream holds 16 bytes.
- R3: With `narrowMode`=0, a serial push goes to the lane of its own pointer, and so does a serial pop, which is shown on `serPopData`. Each pointer starts at lane 0 and steps 0,1,2,3,0 only when its operation is accepted. With `narrowMode`=1 both serial operations use lane 0 and both pointers hold.
- R4: Within one cycle only one push source is served, with priority word > byte > serial. The same rule applies to pops. A push or pop strobe that loses this contest is dropped and counts as an illegal access.
- R5: A push whose target lane(s) hold `DEPTH` entries is dropped and raises the illegal flag. So is a pop whose target lane(s) are empty. Legality is judged on the levels at the start of the cycle. A legal push and a legal pop on the same lane in one cycle both take effect, leaving the level unchanged. With no strobes the levels hold.
- R6: `wordLevel` equals the smallest lane level, which is the number of whole words available. `byteLevel` equals the level of lane 0.
- R7: `status` bit positions are: [0] full (some lane at `DEPTH`), [1] half (some lane at `DEPTH`/2 or more), [2] empty (all lanes empty), [3] word available (all lanes non-empty), [4] byte available (lane 0 non-empty), [5] illegal access. A condition seen at the start of a cycle sets its bit at the end of that cycle. A set bit stays set until it is cleared.
- R8: A one in `clrMask[k]` clears `status[k]` at that edge. For bits 0 to 4, if the condition still holds, the bit sets again one cycle later. For bit 5, an illegal access in the clearing cycle wins, and the bit stays set.
- R9: `softReset` empties all lanes, returns both serial pointers to lane 0 and zeroes `status` at that edge. Every strobe in that cycle is ignored and raises no illegal flag.
- R10: After `rstN` is released, and before the first clock, the levels and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Synchronous flush of data, pointers and flags |
| narrowMode | input | 1 | 1: serial side uses lane 0 only |
| hostWordPush | input | 1 | Push one byte into each lane |
| hostWordData | input | 32 | Word push data, lane i on bits 8i+7:8i |
| hostWordPop | input | 1 | Pop one byte from each lane |
| hostBytePush | input | 1 | Push one byte into lane 0 |
| hostByteData | input | 8 | Byte push data |
| hostBytePop | input | 1 | Pop one byte from lane 0 |
| hostRdData | output | 32 | Heads of the four lanes |
| serPush | input | 1 | Serial-side byte push |
| serPushData | input | 8 | Serial push data |
| serPop | input | 1 | Serial-side byte pop |
| serPopData | output | 8 | Head of the serial pop lane |
| clrMask | input | 6 | Write-one-to-clear for the status bits |
| status | output | 6 | Latched flags, layout in R7 |
| wordLevel | output | 5 | Whole words available |
| byteLevel | output | 5 | Entries in lane 0 |

## Verification
The host side and the serial side can act on the same lane in the same cycle, for example a host byte push while the serial side pops lane 0. A status clear can also meet the condition that sets the same flag in one cycle.

The bench drives these overlaps on purpose:
- a host push at the same time as a serial pop on a partly filled lane;
- a clear of the illegal flag in the same cycle as a pop from an empty lane;
- thousands of random cycles in which every strobe, the clear mask and the mode change freely.

A queue-based model judges every one of these cycles for data order, levels and each flag bit.

// File: rtl/bankfifo_pkg.sv
package bankfifo_pkg;
  localparam int unsigned LANE_COUNT = 4;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned FLAG_COUNT = 6;
  localparam int unsigned LANE_IDX_W = $clog2(LANE_COUNT);

  localparam int unsigned FLG_FULL  = 0;
  localparam int unsigned FLG_HALF  = 1;
  localparam int unsigned FLG_EMPTY = 2;
  localparam int unsigned FLG_WORD  = 3;
  localparam int unsigned FLG_BYTE  = 4;
  localparam int unsigned FLG_ILL   = 5;

  typedef enum logic [1:0] {
    SRC_WORD = 2'd0,
    SRC_BYTE = 2'd1,
    SRC_SER  = 2'd2
  } pushSrc_e;

  typedef struct packed {
    logic                  flush;
    logic [LANE_COUNT-1:0] push;
    logic [LANE_COUNT-1:0] pop;
    pushSrc_e              src;
  } laneStrobe_t;
endpackage

// File: rtl/bankfifo_lane.sv
module bankfifo_lane #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wrData,
  output logic [W-1:0]                 headData,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/bankfifo_datapath.sv
module bankfifo_datapath
  import bankfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  laneStrobe_t                  strobe,
  input  logic [LANE_COUNT*LANE_W-1:0] wordData,
  input  logic [LANE_W-1:0]            byteData,
  input  logic [LANE_W-1:0]            serData,
  output logic [LANE_COUNT*LANE_W-1:0] heads,
  output logic [LANE_COUNT*LW-1:0]     levels
);
  for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
    logic [LANE_W-1:0] laneIn;

    always_comb begin
      case (strobe.src)
        SRC_WORD: laneIn = wordData[i*LANE_W +: LANE_W];
        SRC_BYTE: laneIn = byteData;
        default:  laneIn = serData;
      endcase
    end

    bankfifo_lane #(.DEPTH(DEPTH), .W(LANE_W)) lane_i (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (strobe.flush),
      .push     (strobe.push[i]),
      .pop      (strobe.pop[i]),
      .wrData   (laneIn),
      .headData (heads[i*LANE_W +: LANE_W]),
      .level    (levels[i*LW +: LW])
    );
  end
endmodule

// File: rtl/bankfifo_ctrl.sv
module bankfifo_ctrl
  import bankfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     softReset,
  input  logic                     narrowMode,
  input  logic                     hostWordPush,
  input  logic                     hostWordPop,
  input  logic                     hostBytePush,
  input  logic                     hostBytePop,
  input  logic                     serPush,
  input  logic                     serPop,
  input  logic [FLAG_COUNT-1:0]    clrMask,
  input  logic [LANE_COUNT*LW-1:0] levels,
  output laneStrobe_t              strobe,
  output logic [FLAG_COUNT-1:0]    status,
  output logic [LANE_IDX_W-1:0]    serPopIdx,
  output logic [LW-1:0]            wordLevel,
  output logic [LW-1:0]            byteLevel
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH/2);

  logic [LW-1:0]         lvl [LANE_COUNT];
  logic [LANE_COUNT-1:0] laneFull;
  logic [LANE_COUNT-1:0] laneHalf;
  logic [LANE_COUNT-1:0] laneHas;

  for (genvar i = 0; i < LANE_COUNT; i++) begin : g_cond
    assign lvl[i]      = levels[i*LW +: LW];
    assign laneFull[i] = (lvl[i] == FULL_LVL);
    assign laneHalf[i] = (lvl[i] >= HALF_LVL);
    assign laneHas[i]  = (lvl[i] != '0);
  end

  logic [LANE_IDX_W-1:0] serPushLane;
  logic [LANE_IDX_W-1:0] serPopLane;
  logic [LANE_IDX_W-1:0] serPushIdx;

  assign serPushIdx = narrowMode ? '0 : serPushLane;
  assign serPopIdx  = narrowMode ? '0 : serPopLane;

  logic [LANE_COUNT-1:0] pushMask;
  logic [LANE_COUNT-1:0] popMask;
  pushSrc_e              pushSrc;
  logic                  pushBad;
  logic                  popBad;
  logic                  serPushTaken;
  logic                  serPopTaken;

  always_comb begin
    pushMask     = '0;
    pushSrc      = SRC_SER;
    pushBad      = 1'b0;
    serPushTaken = 1'b0;
    if (hostWordPush) begin
      pushSrc = SRC_WORD;
      if (!(|laneFull)) pushMask = '1;
      else              pushBad  = 1'b1;
      if (hostBytePush || serPush) pushBad = 1'b1;
    end else if (hostBytePush) begin
      pushSrc = SRC_BYTE;
      if (!laneFull[0]) pushMask[0] = 1'b1;
      else              pushBad     = 1'b1;
      if (serPush) pushBad = 1'b1;
    end else if (serPush) begin
      if (!laneFull[serPushIdx]) begin
        pushMask[serPushIdx] = 1'b1;
        serPushTaken         = 1'b1;
      end else begin
        pushBad = 1'b1;
      end
    end
    if (softReset) begin
      pushMask     = '0;
      pushBad      = 1'b0;
      serPushTaken = 1'b0;
    end
  end

  always_comb begin
    popMask     = '0;
    popBad      = 1'b0;
    serPopTaken = 1'b0;
    if (hostWordPop) begin
      if (&laneHas) popMask = '1;
      else          popBad  = 1'b1;
      if (hostBytePop || serPop) popBad = 1'b1;
    end else if (hostBytePop) begin
      if (laneHas[0]) popMask[0] = 1'b1;
      else            popBad     = 1'b1;
      if (serPop) popBad = 1'b1;
    end else if (serPop) begin
      if (laneHas[serPopIdx]) begin
        popMask[serPopIdx] = 1'b1;
        serPopTaken        = 1'b1;
      end else begin
        popBad = 1'b1;
      end
    end
    if (softReset) begin
      popMask     = '0;
      popBad      = 1'b0;
      serPopTaken = 1'b0;
    end
  end

  assign strobe.flush = softReset;
  assign strobe.push  = pushMask;
  assign strobe.pop   = popMask;
  assign strobe.src   = pushSrc;

  function automatic logic [LANE_IDX_W-1:0] nextLane(input logic [LANE_IDX_W-1:0] cur);
    return (cur == LANE_IDX_W'(LANE_COUNT-1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serPushLane <= '0;
      serPopLane  <= '0;
    end else if (softReset) begin
      serPushLane <= '0;
      serPopLane  <= '0;
    end else begin
      if (serPushTaken && !narrowMode) serPushLane <= nextLane(serPushLane);
      if (serPopTaken  && !narrowMode) serPopLane  <= nextLane(serPopLane);
    end
  end

  logic [FLAG_COUNT-2:0] levelCond;
  assign levelCond[FLG_FULL]  = |laneFull;
  assign levelCond[FLG_HALF]  = |laneHalf;
  assign levelCond[FLG_EMPTY] = ~(|laneHas);
  assign levelCond[FLG_WORD]  = &laneHas;
  assign levelCond[FLG_BYTE]  = laneHas[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else if (softReset) begin
      status <= '0;
    end else begin
      for (int k = 0; k < FLAG_COUNT-1; k++) begin
        status[k] <= clrMask[k] ? 1'b0 : (status[k] | levelCond[k]);
      end
      status[FLG_ILL] <= (status[FLG_ILL] & ~clrMask[FLG_ILL]) | pushBad | popBad;
    end
  end

  always_comb begin
    wordLevel = lvl[0];
    for (int i = 1; i < LANE_COUNT; i++) begin
      if (lvl[i] < wordLevel) wordLevel = lvl[i];
    end
  end
  assign byteLevel = lvl[0];
endmodule

// File: rtl/bankfifo_top.sv
module bankfifo_top
  import bankfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         softReset,
  input  logic                         narrowMode,
  input  logic                         hostWordPush,
  input  logic [LANE_COUNT*LANE_W-1:0] hostWordData,
  input  logic                         hostWordPop,
  input  logic                         hostBytePush,
  input  logic [LANE_W-1:0]            hostByteData,
  input  logic                         hostBytePop,
  output logic [LANE_COUNT*LANE_W-1:0] hostRdData,
  input  logic                         serPush,
  input  logic [LANE_W-1:0]            serPushData,
  input  logic                         serPop,
  output logic [LANE_W-1:0]            serPopData,
  input  logic [FLAG_COUNT-1:0]        clrMask,
  output logic [FLAG_COUNT-1:0]        status,
  output logic [LW-1:0]                wordLevel,
  output logic [LW-1:0]                byteLevel
);
  laneStrobe_t                  strobe;
  logic [LANE_COUNT*LW-1:0]     levels;
  logic [LANE_COUNT*LANE_W-1:0] heads;
  logic [LANE_IDX_W-1:0]        serPopIdx;

  bankfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .softReset    (softReset),
    .narrowMode   (narrowMode),
    .hostWordPush (hostWordPush),
    .hostWordPop  (hostWordPop),
    .hostBytePush (hostBytePush),
    .hostBytePop  (hostBytePop),
    .serPush      (serPush),
    .serPop       (serPop),
    .clrMask      (clrMask),
    .levels       (levels),
    .strobe       (strobe),
    .status       (status),
    .serPopIdx    (serPopIdx),
    .wordLevel    (wordLevel),
    .byteLevel    (byteLevel)
  );

  bankfifo_datapath #(.DEPTH(DEPTH)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordData (hostWordData),
    .byteData (hostByteData),
    .serData  (serPushData),
    .heads    (heads),
    .levels   (levels)
  );

  assign hostRdData = heads;
  assign serPopData = heads[serPopIdx*LANE_W +: LANE_W];
endmodule

// File: rtl/bankfifo_checker.sv
module bankfifo_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          softReset,
  input logic          hostWordPush,
  input logic          hostWordPop,
  input logic          hostBytePush,
  input logic          hostBytePop,
  input logic          serPush,
  input logic          serPop,
  input logic [5:0]    clrMask,
  input logic [5:0]    status,
  input logic [LW-1:0] wordLevel,
  input logic [LW-1:0] byteLevel
);
  logic anyPush;
  logic anyPop;
  assign anyPush = hostWordPush | hostBytePush | serPush;
  assign anyPop  = hostWordPop | hostBytePop | serPop;

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (byteLevel <= LW'(DEPTH)) && (wordLevel <= byteLevel));

  p_word_pop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hostWordPop && !softReset && !anyPush && wordLevel != '0)
    |=> (wordLevel == $past(wordLevel) - 1'b1));

  p_empty_pop_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostBytePop && !hostWordPop && !softReset && byteLevel == '0)
    |=> status[5]);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!anyPush && !anyPop && !softReset)
    |=> ($stable(byteLevel) && $stable(wordLevel)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|clrMask[4:0]) |=> ((status[4:0] & $past(clrMask[4:0])) == 5'b0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !clrMask[0] && !softReset) |=> status[0]);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (byteLevel == '0 && wordLevel == '0 && status == 6'b0));
endmodule

bind bankfifo_top bankfifo_checker #(.DEPTH(DEPTH)) checker_i (
  .clk          (clk),
  .rstN         (rstN),
  .softReset    (softReset),
  .hostWordPush (hostWordPush),
  .hostWordPop  (hostWordPop),
  .hostBytePush (hostBytePush),
  .hostBytePop  (hostBytePop),
  .serPush      (serPush),
  .serPop       (serPop),
  .clrMask      (clrMask),
  .status       (status),
  .wordLevel    (wordLevel),
  .byteLevel    (byteLevel)
);

// File: tb/bankfifo_top_tb_top.sv
`timescale 1ns/1ps
module bankfifo_top_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softReset = 1'b0;
  logic        narrowMode = 1'b0;
  logic        hostWordPush = 1'b0;
  logic [31:0] hostWordData = '0;
  logic        hostWordPop = 1'b0;
  logic        hostBytePush = 1'b0;
  logic [7:0]  hostByteData = '0;
  logic        hostBytePop = 1'b0;
  logic [31:0] hostRdData;
  logic        serPush = 1'b0;
  logic [7:0]  serPushData = '0;
  logic        serPop = 1'b0;
  logic [7:0]  serPopData;
  logic [5:0]  clrMask = '0;
  logic [5:0]  status;
  logic [4:0]  wordLevel;
  logic [4:0]  byteLevel;

  always #10 clk = ~clk;

  bankfifo_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .softReset(softReset), .narrowMode(narrowMode),
    .hostWordPush(hostWordPush), .hostWordData(hostWordData), .hostWordPop(hostWordPop),
    .hostBytePush(hostBytePush), .hostByteData(hostByteData), .hostBytePop(hostBytePop),
    .hostRdData(hostRdData), .serPush(serPush), .serPushData(serPushData),
    .serPop(serPop), .serPopData(serPopData), .clrMask(clrMask), .status(status),
    .wordLevel(wordLevel), .byteLevel(byteLevel)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] q [4][$];
  bit [5:0]   mFlag;
  int         mPushPtr;
  int         mPopPtr;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) q[i].delete();
    mFlag = '0;
    mPushPtr = 0;
    mPopPtr = 0;
  endtask

  task automatic modelStep();
    int lv[4];
    bit c[5];
    bit bad;
    int pi;
    int oi;
    bit allRoom;
    bit allHave;
    if (softReset) begin
      modelReset();
      return;
    end
    for (int i = 0; i < 4; i++) lv[i] = q[i].size();
    c[0] = 0; c[1] = 0; c[2] = 1; c[3] = 1; c[4] = (lv[0] > 0);
    allRoom = 1; allHave = 1;
    for (int i = 0; i < 4; i++) begin
      if (lv[i] == DEPTH) begin c[0] = 1; allRoom = 0; end
      if (lv[i] >= DEPTH/2) c[1] = 1;
      if (lv[i] != 0) c[2] = 0;
      if (lv[i] == 0) begin c[3] = 0; allHave = 0; end
    end
    pi = narrowMode ? 0 : mPushPtr;
    oi = narrowMode ? 0 : mPopPtr;
    bad = 0;
    if (hostWordPop) begin
      if (allHave) for (int i = 0; i < 4; i++) void'(q[i].pop_front());
      else bad = 1;
      if (hostBytePop || serPop) bad = 1;
    end else if (hostBytePop) begin
      if (lv[0] > 0) void'(q[0].pop_front()); else bad = 1;
      if (serPop) bad = 1;
    end else if (serPop) begin
      if (lv[oi] > 0) begin
        void'(q[oi].pop_front());
        if (!narrowMode) mPopPtr = (mPopPtr + 1) % 4;
      end else bad = 1;
    end
    if (hostWordPush) begin
      if (allRoom) for (int i = 0; i < 4; i++) q[i].push_back(hostWordData[8*i +: 8]);
      else bad = 1;
      if (hostBytePush || serPush) bad = 1;
    end else if (hostBytePush) begin
      if (lv[0] < DEPTH) q[0].push_back(hostByteData); else bad = 1;
      if (serPush) bad = 1;
    end else if (serPush) begin
      if (lv[pi] < DEPTH) begin
        q[pi].push_back(serPushData);
        if (!narrowMode) mPushPtr = (mPushPtr + 1) % 4;
      end else bad = 1;
    end
    for (int k = 0; k < 5; k++) mFlag[k] = clrMask[k] ? 1'b0 : (mFlag[k] | c[k]);
    mFlag[5] = (mFlag[5] & ~clrMask[5]) | bad;
  endtask

  task automatic compare();
    int mn;
    int oi;
    mn = q[0].size();
    for (int i = 1; i < 4; i++) if (q[i].size() < mn) mn = q[i].size();
    chk(wordLevel == mn, "R6", "wordLevel", wordLevel, mn);
    chk(byteLevel == q[0].size(), "R6 R2", "byteLevel", byteLevel, q[0].size());
    chk(status == mFlag, "R7 R8", "status", status, mFlag);
    for (int i = 0; i < 4; i++) begin
      if (q[i].size() > 0)
        chk(hostRdData[8*i +: 8] == q[i][0], "R1", "lane head", hostRdData[8*i +: 8], q[i][0]);
    end
    oi = narrowMode ? 0 : mPopPtr;
    if (q[oi].size() > 0)
      chk(serPopData == q[oi][0], "R3", "serPopData", serPopData, q[oi][0]);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    softReset = 0; hostWordPush = 0; hostWordPop = 0; hostBytePush = 0;
    hostBytePop = 0; serPush = 0; serPop = 0; clrMask = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(status == 0, "R10", "status after reset", status, 0);
    chk(wordLevel == 0 && byteLevel == 0, "R10", "levels after reset", byteLevel, 0);

    idle(); cyc();
    chk(status[2] == 1, "R7", "empty flag", status[2], 1);

    for (int i = 0; i < 16; i++) begin
      hostWordPush = 1; hostWordData = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
      cyc();
    end
    chk(wordLevel == 16, "R1", "16 words held", wordLevel, 16);
    hostWordData = 32'hdeadbeef; cyc();
    idle();
    chk(wordLevel == 16, "R5", "push into full dropped", wordLevel, 16);
    chk(status[5] == 1, "R5", "illegal after full push", status[5], 1);

    clrMask = 6'b000001; cyc(); idle();
    chk(status[0] == 0, "R8", "full cleared", status[0], 0);
    cyc();
    chk(status[0] == 1, "R8", "full reasserts", status[0], 1);

    for (int i = 0; i < 5; i++) begin
      serPop = 1;
      #1;
      chk(serPopData == 8'(i), "R3", "wide lane order", serPopData, i);
      cyc();
    end
    idle();
    chk(wordLevel == 14 && byteLevel == 14, "R3", "levels after serial pops", wordLevel, 14);

    clrMask = 6'b100000; cyc(); idle();
    chk(status[5] == 0, "R8", "illegal cleared", status[5], 0);
    hostWordPush = 1; hostWordData = 32'h44332211; hostBytePush = 1; hostByteData = 8'h99;
    cyc(); idle();
    chk(byteLevel == 15, "R4", "word beats byte push", byteLevel, 15);
    chk(status[5] == 1, "R4", "dropped byte push flagged", status[5], 1);

    softReset = 1; hostWordPush = 1; hostBytePop = 1; cyc(); idle();
    chk(byteLevel == 0 && wordLevel == 0, "R9", "soft reset levels", byteLevel, 0);
    chk(status == 0, "R9", "soft reset flags", status, 0);
    cyc();
    chk(status[5] == 0, "R9", "strobes ignored in soft reset", status[5], 0);

    narrowMode = 1;
    for (int i = 0; i < 17; i++) begin
      hostBytePush = 1; hostByteData = 8'(8'h40 + i); cyc();
    end
    idle();
    chk(byteLevel == 16 && wordLevel == 0, "R2", "byte capacity 16", byteLevel, 16);
    chk(status[5] == 1, "R2", "17th byte flagged", status[5], 1);
    serPop = 1;
    for (int i = 0; i < 3; i++) begin
      #1; chk(serPopData == 8'(8'h40 + i), "R3", "narrow lane 0", serPopData, 8'h40 + i); cyc();
    end
    hostBytePush = 1; hostByteData = 8'h77; cyc(); idle();
    chk(byteLevel == 13, "R5", "push and pop same lane", byteLevel, 13);
    serPop = 1;
    repeat (13) cyc();
    idle();
    clrMask = 6'b100000; hostBytePop = 1; cyc(); idle();
    chk(status[5] == 1, "R8", "event beats clear", status[5], 1);
    narrowMode = 0;

    for (int n = 0; n < 4000; n++) begin
      softReset    = (($urandom % 97) == 0);
      hostWordPush = (($urandom % 6) == 0);
      hostWordPop  = (($urandom % 7) == 0);
      hostBytePush = (($urandom % 8) == 0);
      hostBytePop  = (($urandom % 8) == 0);
      serPush      = (($urandom % 3) == 0);
      serPop       = (($urandom % 3) == 0);
      hostWordData = $urandom;
      hostByteData = 8'($urandom);
      serPushData  = 8'($urandom);
      clrMask      = (($urandom % 5) == 0) ? 6'($urandom) : 6'b0;
      if (($urandom % 150) == 0) narrowMode = ~narrowMode;
      cyc();
    end
    idle(); cyc();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule